// File: doc/BRIEF.md
# Byte-Command I2C Master Controller

This block is an I2C bus master that software steers one byte at a time through four word registers: control, status, own address and data buffer. Each byte transfer is a single command. Setting the transfer bit in the control register launches it, and the start, stop and not-acknowledge bits qualify that command. A START-qualified command sends the data buffer byte as an address byte. The direction of every later byte on that bus ownership comes from bit 0 of that address byte: 1 means read and 0 means write.

The controller drives the open-drain SCL and SDA wires only through active-high output enables (enable = pull low) and reads the wire levels back. One bit takes four quarter phases, and each quarter phase lasts a parameterised number of system clocks. Completed bytes, lost arbitration and a missing acknowledge each raise a sticky status flag. An interrupt line is active while any flag with its enable bit set is pending.

Register words (reg_addr): 0 control, 1 status, 2 own address (7 bits, storage only), 3 data buffer. Control bits: 0 start, 1 stop, 2 nack, 3 go, 4 unit enable, 5 clock enable, 6 unit reset, 8..11 interrupt enables for transmit-empty, receive-full, arbitration-lost and bus-error. Status bits: 0 busy, 1 transmit-empty, 2 receive-full, 3 arbitration-lost, 4 bus-error.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, control and status read 0, irq is 0, and scl_oe and sda_oe are 0.
- R2: A go command with start (control bit 0) produces a START, or a repeated START if the bus is owned, and then shifts out the data buffer byte MSB first. When the target acknowledges, transmit-empty (status bit 1) is set.
- R3: A go command without start on an owned bus in write direction shifts out the data buffer byte and sets transmit-empty. With stop (control bit 1) set, a STOP follows the byte.
- R4: In read direction, the received byte appears in the data buffer and receive-full (status bit 2) is set. The master acknowledges the byte unless nack (control bit 2) is set, in which case it sends NACK, and with stop also set it then sends a STOP.
- R5: A start-qualified command on an owned bus produces a repeated START with no STOP before it, and the new address byte sets the direction.
- R6: Writing 1 to a status bit 1..4 clears only that flag. Writing 0 leaves it unchanged. A flag event in the same cycle as the clear wins.
- R7: irq is 1 exactly while some flag is set whose enable is set. The enables are control bits 8 (transmit-empty), 9 (receive-full), 10 (arbitration-lost) and 11 (bus-error).
- R8: When the master releases SDA during SCL high and samples SDA low, it sets arbitration-lost (status bit 3), releases both lines, clears busy and ends the command.
- R9: If a transmitted byte is not acknowledged, bus-error (status bit 4) is set, both lines are released, busy clears and the command ends.
- R10: Busy (status bit 0) is set from the START until the STOP completes or the command aborts. While busy is 0, scl_oe and sda_oe are 0.
- R11: One SCL period lasts 4*QDIV clock cycles.
- R12: SCL is driven and commands are accepted only when unit enable (bit 4) and clock enable (bit 5) are both set. Go (bit 3), start and stop clear themselves when the command ends.
- R13: Writing a control word with unit reset (bit 6) set returns the engine to idle, releases both lines and clears the whole control register. The status flags are kept.
- R14: A go command without start while the bus is not owned is dropped. Go clears, no flag changes and no bus activity occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select (0 ctrl, 1 status, 2 own address, 3 data) |
| reg_wdata | input | 12 | Register write data |
| reg_rdata | output | 12 | Register read data of the selected word |
| irq | output | 1 | Interrupt request |
| scl_in | input | 1 | Sampled SCL wire level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_in | input | 1 | Sampled SDA wire level |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bench builds the block with QDIV = 2, so one bus bit lasts eight clocks. That short bit time lets a single run write every one of the 256 byte values through the block to a bus target model, and also cover multi-byte reads, repeated START, a refused address, a jammed SDA line and unit reset mid-transfer. With QDIV = 2 the SCL period check compares against a small exact count of 8 cycles.

// File: rtl/i2cbm_pkg.sv
package i2cbm_pkg;
  localparam int REG_W = 12;

  localparam int CB_START   = 0;
  localparam int CB_STOP    = 1;
  localparam int CB_NACK    = 2;
  localparam int CB_GO      = 3;
  localparam int CB_UEN     = 4;
  localparam int CB_SCLEN   = 5;
  localparam int CB_URST    = 6;
  localparam int CB_IE_LO   = 8;
  localparam int CB_IE_HI   = 11;

  localparam int SB_BUSY    = 0;
  localparam int SB_FLAG_LO = 1;
  localparam int SB_FLAG_HI = 4;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_OWN  = 2'd2;
  localparam logic [1:0] A_DBUF = 2'd3;

  localparam int EV_TXE  = 0;
  localparam int EV_RXF  = 1;
  localparam int EV_AL   = 2;
  localparam int EV_BERR = 3;

  typedef enum logic [2:0] {
    E_IDLE, E_START, E_BIT, E_ACK, E_STOP, E_HOLD
  } eng_state_e;
endpackage

// File: rtl/i2cbm_tick.sv
module i2cbm_tick #(
  parameter int QDIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(QDIV) + 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == CW'(QDIV - 1));
    cnt_d = cnt_q + CW'(1);
    if (!run || tick) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2cbm_engine.sv
module i2cbm_engine
  import i2cbm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       tick,
  input  logic       run,
  input  logic       go,
  input  logic       cmd_start,
  input  logic       cmd_stop,
  input  logic       cmd_nack,
  input  logic [7:0] tx_byte,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_low,
  output logic       sda_low,
  output logic       busy,
  output logic [3:0] evt,
  output logic       done,
  output logic [7:0] rx_byte
);
  eng_state_e st_q, st_d;
  logic [1:0] ph_q, ph_d;
  logic [2:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic samp_q, samp_d, rdm_q, rdm_d, xmit_q, xmit_d;
  logic stop_q, stop_d, nack_q, nack_d, busy_q, busy_d;
  logic last_ph;

  assign last_ph = tick && (ph_q == 2'd3);

  always_comb begin
    st_d = st_q; ph_d = ph_q; bit_d = bit_q; sh_d = sh_q; samp_d = samp_q;
    rdm_d = rdm_q; xmit_d = xmit_q; stop_d = stop_q; nack_d = nack_q;
    busy_d = busy_q; evt = '0; done = 1'b0;
    if (tick) ph_d = ph_q + 2'd1;
    case (st_q)
      E_IDLE, E_HOLD: begin
        ph_d = '0;
        if (go && run) begin
          sh_d = tx_byte; stop_d = cmd_stop; nack_d = cmd_nack; bit_d = 3'd7;
          if (cmd_start) begin
            st_d = E_START; rdm_d = tx_byte[0]; xmit_d = 1'b1; busy_d = 1'b1;
          end else if (st_q == E_HOLD) begin
            st_d = E_BIT; xmit_d = ~rdm_q;
          end else begin
            done = 1'b1;
          end
        end
      end
      E_START: if (last_ph) st_d = E_BIT;
      E_BIT: begin
        if (tick && ph_q == 2'd2) begin
          samp_d = sda_in;
          if (xmit_q && sh_q[7] && scl_in && !sda_in) begin
            st_d = E_IDLE; busy_d = 1'b0; evt[EV_AL] = 1'b1; done = 1'b1;
          end
        end
        if (last_ph) begin
          sh_d = {sh_q[6:0], samp_q};
          if (bit_q == 3'd0) st_d = E_ACK;
          else               bit_d = bit_q - 3'd1;
        end
      end
      E_ACK: begin
        if (tick && ph_q == 2'd2) samp_d = sda_in;
        if (last_ph) begin
          if (xmit_q && samp_q) begin
            st_d = E_IDLE; busy_d = 1'b0; evt[EV_BERR] = 1'b1; done = 1'b1;
          end else begin
            evt[EV_TXE] = xmit_q;
            evt[EV_RXF] = ~xmit_q;
            if (stop_q) st_d = E_STOP;
            else begin st_d = E_HOLD; done = 1'b1; end
          end
        end
      end
      E_STOP: if (last_ph) begin st_d = E_IDLE; busy_d = 1'b0; done = 1'b1; end
      default: st_d = E_IDLE;
    endcase
    if (clr) begin
      st_d = E_IDLE; busy_d = 1'b0; ph_d = '0; evt = '0; done = 1'b0;
    end
  end

  always_comb begin
    scl_low = 1'b0;
    sda_low = 1'b0;
    case (st_q)
      E_HOLD:  scl_low = 1'b1;
      E_START: begin scl_low = (ph_q == 2'd0) || (ph_q == 2'd3); sda_low = ph_q[1]; end
      E_BIT:   begin scl_low = (ph_q == 2'd0) || (ph_q == 2'd3); sda_low = xmit_q & ~sh_q[7]; end
      E_ACK:   begin scl_low = (ph_q == 2'd0) || (ph_q == 2'd3); sda_low = ~xmit_q & ~nack_q; end
      E_STOP:  begin scl_low = (ph_q == 2'd0); sda_low = ~ph_q[1]; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= E_IDLE; ph_q <= '0; bit_q <= '0; sh_q <= '0; samp_q <= 1'b1;
      rdm_q <= 1'b0; xmit_q <= 1'b0; stop_q <= 1'b0; nack_q <= 1'b0; busy_q <= 1'b0;
    end else begin
      st_q <= st_d; ph_q <= ph_d; bit_q <= bit_d; sh_q <= sh_d; samp_q <= samp_d;
      rdm_q <= rdm_d; xmit_q <= xmit_d; stop_q <= stop_d; nack_q <= nack_d; busy_q <= busy_d;
    end
  end

  assign busy    = busy_q;
  assign rx_byte = sh_q;
endmodule

// File: rtl/i2cbm_regs.sv
module i2cbm_regs
  import i2cbm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic [3:0]       evt,
  input  logic             done,
  input  logic             busy,
  input  logic [7:0]       rx_byte,
  output logic [REG_W-1:0] ctrl,
  output logic [3:0]       flags,
  output logic [7:0]       dbuf,
  output logic             unit_clr,
  output logic             irq
);
  logic [REG_W-1:0] ctrl_q, ctrl_d;
  logic [3:0]       flags_q, flags_d;
  logic [7:0]       dbuf_q, dbuf_d;
  logic [6:0]       own_q, own_d;

  always_comb begin
    unit_clr = we && (addr == A_CTRL) && wdata[CB_URST];
    ctrl_d   = ctrl_q;
    if (done) begin
      ctrl_d[CB_START] = 1'b0;
      ctrl_d[CB_STOP]  = 1'b0;
      ctrl_d[CB_GO]    = 1'b0;
    end
    if (we && addr == A_CTRL) ctrl_d = unit_clr ? '0 : wdata;
    flags_d = flags_q;
    if (we && addr == A_STAT) flags_d = flags_q & ~wdata[SB_FLAG_HI:SB_FLAG_LO];
    flags_d = flags_d | evt;
    dbuf_d = dbuf_q;
    if (we && addr == A_DBUF) dbuf_d = wdata[7:0];
    if (evt[EV_RXF])          dbuf_d = rx_byte;
    own_d = own_q;
    if (we && addr == A_OWN)  own_d = wdata[6:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; flags_q <= '0; dbuf_q <= '0; own_q <= '0;
    end else begin
      ctrl_q <= ctrl_d; flags_q <= flags_d; dbuf_q <= dbuf_d; own_q <= own_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: rdata = ctrl_q;
      A_STAT: rdata = REG_W'({flags_q, busy});
      A_OWN:  rdata = REG_W'(own_q);
      default: rdata = REG_W'(dbuf_q);
    endcase
  end

  assign irq   = |(flags_q & ctrl_q[CB_IE_HI:CB_IE_LO]);
  assign ctrl  = ctrl_q;
  assign flags = flags_q;
  assign dbuf  = dbuf_q;
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cbm_pkg::*;
#(
  parameter int QDIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq,
  input  logic             scl_in,
  output logic             scl_oe,
  input  logic             sda_in,
  output logic             sda_oe
);
  logic [REG_W-1:0] ctrl_q;
  logic [3:0]       flags_q, evt;
  logic [7:0]       dbuf, rx_byte;
  logic             unit_clr, tick, run, done, busy, scl_low, sda_low;

  assign run = ctrl_q[CB_UEN] & ctrl_q[CB_SCLEN];

  i2cbm_tick #(.QDIV(QDIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  i2cbm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .evt(evt), .done(done), .busy(busy), .rx_byte(rx_byte),
    .ctrl(ctrl_q), .flags(flags_q), .dbuf(dbuf), .unit_clr(unit_clr), .irq(irq)
  );

  i2cbm_engine u_eng (
    .clk(clk), .rst_n(rst_n), .clr(unit_clr), .tick(tick), .run(run),
    .go(ctrl_q[CB_GO]), .cmd_start(ctrl_q[CB_START]), .cmd_stop(ctrl_q[CB_STOP]),
    .cmd_nack(ctrl_q[CB_NACK]), .tx_byte(dbuf), .scl_in(scl_in), .sda_in(sda_in),
    .scl_low(scl_low), .sda_low(sda_low), .busy(busy), .evt(evt), .done(done),
    .rx_byte(rx_byte)
  );

  assign scl_oe = scl_low & run;
  assign sda_oe = sda_low & ctrl_q[CB_UEN];
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       irq,
  input logic       busy,
  input logic       go,
  input logic [3:0] flags,
  input logic       clr_txe
);
  a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  a_r7_no_flag_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == 4'd0) |-> !irq);

  a_r6_txe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !clr_txe) |=> flags[0]);

  a_r8_al_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[2]) |-> (!busy && !sda_oe));

  a_r9_berr_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[3]) |-> !busy);

  a_r12_go_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !go);
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq),
  .busy(busy), .go(ctrl_q[3]), .flags(flags_q),
  .clr_txe(reg_we && (reg_addr == 2'd1) && reg_wdata[1])
);

// File: tb/i2c_byte_master_tb.sv
module i2c_byte_master_tb_top;
  localparam int QDIV = 2;
  localparam int EN = 'h30, IEA = 'hF00, GO = 8, ST = 1, SP = 2, NK = 4, UR = 'h40;
  localparam logic [6:0] SLV = 7'h2A;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [11:0] reg_wdata = '0, reg_rdata;
  logic irq, scl_oe, sda_oe, scl_line, sda_line;
  logic slv_low = 1'b0, jam = 1'b0;
  int checks = 0, errors = 0, ie_cur = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | slv_low | jam);

  i2c_byte_master #(.QDIV(QDIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_in(scl_line), .scl_oe(scl_oe), .sda_in(sda_line), .sda_oe(sda_oe)
  );

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 37 + 'h5A) & 'hFF);
  endfunction

  // bus target model
  int start_n = 0, stop_n = 0, bitcnt = 0, rx_n = 0, k = 0, ack_n = 0, nack_n = 0;
  bit active = 0, fresh = 0, first = 0, rd = 0, addr_ok = 0, mnack = 0;
  logic [7:0] rxsh = '0, txb = '0;
  logic [7:0] rx_log [0:511];
  time last_rise = 0, prev_rise = 0;

  always @(negedge sda_line) if (scl_line === 1'b1) begin
    start_n++; active = 1; fresh = 1; bitcnt = 0; first = 1; slv_low = 0;
  end
  always @(posedge sda_line) if (scl_line === 1'b1) begin
    stop_n++; active = 0; slv_low = 0;
  end
  always @(posedge scl_line) begin
    prev_rise = last_rise; last_rise = $time;
    if (active) begin
      if (bitcnt < 8) rxsh = {rxsh[6:0], sda_line};
      else            mnack = sda_line;
    end
  end
  always @(negedge scl_line) if (active) begin
    if (fresh) fresh = 0;
    else begin
      bitcnt++;
      if (bitcnt == 8) begin
        if (first) begin
          rd = rxsh[0]; addr_ok = (rxsh[7:1] == SLV); slv_low = addr_ok;
        end else if (!rd) begin
          rx_log[rx_n] = rxsh; rx_n++; slv_low = 1;
        end else slv_low = 0;
      end else if (bitcnt == 9) begin
        bitcnt = 0;
        if (first) begin first = 0; mnack = 0; end
        else if (rd) begin if (mnack) nack_n++; else ack_n++; end
        if (rd && !mnack && addr_ok) begin txb = pat(k); k++; slv_low = ~txb[7]; end
        else slv_low = 0;
      end else slv_low = (rd && !first && !mnack) ? ~txb[7 - bitcnt] : 1'b0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = 12'(d);
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rdreg(input logic [1:0] a, output logic [11:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic wait_go();
    logic [11:0] v;
    for (int i = 0; i < 4000; i++) begin
      rdreg(0, v);
      if (!v[3]) return;
    end
    chk("R12 go never cleared", 1, 0);
  endtask

  task automatic cmd(input logic [7:0] b, input int bits);
    wr(3, b); wr(0, EN | ie_cur | bits | GO); wait_go();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [11:0] v;
    int exp_k, s0, p0, ok;
    repeat (5) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rdreg(0, v); chk("R1 ctrl", v, 0);
    rdreg(1, v); chk("R1 status", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 lines", {scl_oe, sda_oe}, 0);

    ie_cur = IEA;
    // R2 address write, R10 busy
    s0 = start_n;
    cmd({SLV, 1'b0}, ST);
    rdreg(1, v); chk("R2 txe after address", v[1], 1); chk("R10 busy while owned", v[0], 1);
    chk("R2 START seen", start_n - s0, 1);
    chk("R7 irq with txe enabled", irq, 1);
    // R7 enable positions
    wr(0, EN | 'h200); #1 chk("R7 irq masked by rxf-only enable", irq, 0);
    wr(0, EN | 'h100); #1 chk("R7 irq txe enable bit 8", irq, 1);
    wr(1, 2); rdreg(1, v); chk("R6 txe cleared", v[1], 0);
    chk("R7 irq drops after clear", irq, 0);
    wr(0, EN | ie_cur);

    // R3 sweep all 256 byte values
    p0 = stop_n;
    for (int b = 0; b < 256; b++) begin
      cmd(8'(b), (b == 255) ? SP : 0);
      rdreg(1, v);
      if (v[1] !== 1'b1) chk("R3 txe per byte", v[1], 1);
      if (b == 10) chk("R11 SCL period", int'(last_rise - prev_rise), 4 * QDIV * 10);
      wr(1, 2);
    end
    ok = 1;
    for (int b = 0; b < 256; b++) if (rx_log[b] !== 8'(b)) ok = 0;
    chk("R3 target received all bytes", ok, 1);
    chk("R3 byte count", rx_n, 256);
    chk("R3 STOP after last", stop_n - p0, 1);
    rdreg(1, v); chk("R10 busy cleared after STOP", v[0], 0);

    // R4 read 8 bytes
    exp_k = 0;
    cmd({SLV, 1'b1}, ST); wr(1, 'h1E);
    for (int i = 0; i < 8; i++) begin
      cmd(8'h00, (i == 7) ? (NK | SP) : 0);
      rdreg(1, v); chk("R4 rxf", v[2], 1);
      rdreg(3, v); chk("R4 data byte", v[7:0], pat(exp_k)); exp_k++;
      wr(1, 'h1E);
    end
    chk("R4 master ACK count", ack_n, 7);
    chk("R4 master NACK count", nack_n, 1);
    rdreg(1, v); chk("R4 busy after NACK+STOP", v[0], 0);

    // R5 repeated START
    s0 = start_n; p0 = stop_n;
    cmd({SLV, 1'b0}, ST); cmd(8'hC3, 0);
    cmd({SLV, 1'b1}, ST);
    chk("R5 two STARTs without STOP", start_n - s0, 2);
    chk("R5 no STOP between", stop_n - p0, 0);
    cmd(8'h00, NK | SP);
    rdreg(3, v); chk("R5 read after repeated START", v[7:0], pat(exp_k)); exp_k++;
    chk("R5 write byte delivered", rx_log[rx_n - 1], 'hC3);

    // R6 selective clear
    rdreg(1, v); chk("R6 txe and rxf both pending", v[2:1], 2'b11);
    wr(1, 2); rdreg(1, v); chk("R6 rxf kept when txe cleared", v[2:1], 2'b10);
    wr(1, 0); rdreg(1, v); chk("R6 write of 0 keeps rxf", v[2], 1);
    wr(1, 'h1E);

    // R9 unacknowledged address
    cmd({SLV + 7'd1, 1'b0}, ST);
    rdreg(1, v); chk("R9 bus-error flag", v[4], 1); chk("R9 busy cleared", v[0], 0);
    chk("R9 lines released", {scl_oe, sda_oe}, 0);
    wr(1, 'h1E);

    // R8 arbitration loss
    cmd({SLV, 1'b0}, ST); wr(1, 'h1E);
    jam = 1; cmd(8'hFF, 0);
    rdreg(1, v); chk("R8 arbitration-lost flag", v[3], 1); chk("R8 busy cleared", v[0], 0);
    chk("R8 sda released", sda_oe, 0);
    chk("R8 no txe", v[1], 0);
    jam = 0; wr(1, 'h1E);

    // R14 go without start on a free bus
    s0 = start_n;
    wr(0, EN | GO); repeat (20) @(negedge clk);
    rdreg(0, v); chk("R14 go dropped", v[3], 0);
    rdreg(1, v); chk("R14 no flag no busy", v, 0);
    chk("R14 no bus activity", start_n - s0, 0);

    // R12 gating by clock enable
    wr(0, 'h10 | ST | GO); repeat (100) @(negedge clk);
    rdreg(0, v); chk("R12 go stays pending without clock enable", v[3], 1);
    chk("R12 scl not driven", scl_oe, 0);
    rdreg(1, v); chk("R12 not busy", v[0], 0);
    // R13 unit reset
    wr(0, UR | EN); rdreg(0, v); chk("R13 ctrl cleared", v, 0);
    cmd({SLV, 1'b0}, ST); wr(1, 'h1E);
    rdreg(1, v); chk("R13 owned before reset", v[0], 1);
    wr(0, UR); rdreg(1, v); chk("R13 busy cleared", v[0], 0);
    chk("R13 lines released", {scl_oe, sda_oe}, 0);
    wr(1, 'h1E);
    finish_run();
  end
endmodule